// File: doc/BRIEF.md
# Flash Read-While-Busy Response Controller

This block sits between a bus read port and a flash array that may be busy with a program or erase operation. A read that arrives while the array is busy is handled according to a 3-bit policy field. The read can end at once with an error, or it can be held in a stall until the array goes idle. A stall can also ask the array to abandon its operation, and it can set a stall or an abort notification flag. A one-line holding register of 128 bits sits beside the array and answers repeat reads of the last fetched line without touching the array.

Reads use a single-cycle request pulse. The answer is a one-cycle acknowledge carrying data or an error flag. A hit in the holding register is answered one cycle after the request. An array fetch is answered two cycles after the array read is issued. A strap input marks a single-bank build. In that build the policy field is not used and every busy read is stalled.

Top module: `flash_rwb_ctrl`

## Requirements
- R1: After reset the policy field reads 3'b111, the buffer enable reads 1, both notification outputs are 0, and rd_ack and rd_stall are 0.
- R2: With policy bit 2 equal to 0, a read that misses the holding register while arr_busy is 1 is acknowledged one cycle after the request with rd_err=1 and rd_data=0. No array read is issued for it.
- R3: With policy 3'b111, a missing read during busy raises rd_stall from the cycle after the request. The array is never read while arr_busy is 1. The read completes with array data two cycles after the first idle cycle of the array. No flag is set and no abort is issued.
- R4: With policy 3'b110, a stalled read sets the stall notification flag (irq_stall) on the cycle after the request. No abort is issued.
- R5: With policy 3'b101, a stalled read drives arr_abort high for exactly one cycle, the cycle after the request. It does not set irq_abort.
- R6: With policy 3'b100, a stalled read issues the same abort pulse and also sets irq_abort.
- R7: A missing read while the array is idle reads the array with the request address. It returns the line two cycles after the request with rd_err=0. It loads the line and its address tag into the holding register when the buffer enable is 1.
- R8: A read whose address equals the valid tag, while the buffer enable is 1, is answered from the holding register one cycle after the request with rd_err=0. This holds even while the array is busy.
- R9: While the buffer enable is 0 the holding register serves no read and is not filled. Clearing the enable invalidates it, so setting the enable to 1 again does not bring back the old hit.
- R10: Each notification flag is sticky and drives its output as a level. It is cleared by irq_clr_wr with a 1 in its bit of irq_clr_wd (bit 0 is stall, bit 1 is abort).
- R11: With bank_single=1 the policy field is ignored and a busy read stalls as under 3'b111, even when the field holds 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the policy field and the buffer enable |
| cfg_mode_wd | input | 3 | New policy value |
| cfg_bufen_wd | input | 1 | New buffer enable value |
| irq_clr_wr | input | 1 | Write-one-to-clear strobe for the flags |
| irq_clr_wd | input | 2 | Clear mask: bit 0 stall, bit 1 abort |
| bank_single | input | 1 | Single-bank strap; forces stall behaviour |
| cfg_mode_rd | output | 3 | Current policy field |
| cfg_bufen_rd | output | 1 | Current buffer enable |
| rd_req | input | 1 | Read request pulse |
| rd_addr | input | AW | Line address of the read |
| rd_stall | output | 1 | Read is being held |
| rd_ack | output | 1 | Read response pulse |
| rd_err | output | 1 | Response is an error |
| rd_data | output | LW | Response line |
| arr_busy | input | 1 | Array is programming or erasing |
| arr_rd_en | output | 1 | Array read strobe |
| arr_addr | output | AW | Array read address |
| arr_rdata | input | LW | Array line, valid the cycle after arr_rd_en |
| arr_abort | output | 1 | Request to abandon the array operation |
| irq_stall | output | 1 | Stall notification level |
| irq_abort | output | 1 | Abort notification level |

## Verification
The bench forces every busy-read policy against a controlled array and checks the exact response cycle of each read. A decoder that looks at the wrong policy bit would return an error where a stall is due, or hang where an error is due. An abort issued one cycle late, or an array read launched while busy, shifts the acknowledge cycle. The bench also reads a cached line while the array is busy and the policy is error. A design that checks busy before the holding register would return an error there instead of data. Reads after the buffer enable is toggled expose a design that keeps a stale valid bit. A single-bank read under policy 3'b000 exposes a strap that is not honoured.

// File: rtl/frwb_pkg.sv
package frwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STALL = 2'd1,
    ST_FETCH = 2'd2
  } rwb_st_e;

  localparam logic [2:0] POL_STALL_ONLY = 3'b111;
  localparam logic [2:0] POL_STALL_IRQ  = 3'b110;
  localparam logic [2:0] POL_ABORT_IRQ  = 3'b100;
endpackage

// File: rtl/frwb_regs.sv
module frwb_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr_i,
  input  logic [2:0] mode_wd_i,
  input  logic       bufen_wd_i,
  input  logic       clr_wr_i,
  input  logic [1:0] clr_wd_i,
  input  logic       set_stall_i,
  input  logic       set_abort_i,
  output logic [2:0] mode_o,
  output logic       bufen_o,
  output logic       irq_stall_o,
  output logic       irq_abort_o
);
  logic [2:0] mode_q;
  logic       bufen_q;
  logic       stl_q, stl_d;
  logic       abt_q, abt_d;

  always_comb begin
    stl_d = stl_q;
    abt_d = abt_q;
    if (clr_wr_i && clr_wd_i[0]) stl_d = 1'b0;
    if (clr_wr_i && clr_wd_i[1]) abt_d = 1'b0;
    if (set_stall_i) stl_d = 1'b1;
    if (set_abort_i) abt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= frwb_pkg::POL_STALL_ONLY;
      bufen_q <= 1'b1;
    end else if (cfg_wr_i) begin
      mode_q  <= mode_wd_i;
      bufen_q <= bufen_wd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stl_q <= 1'b0;
      abt_q <= 1'b0;
    end else begin
      stl_q <= stl_d;
      abt_q <= abt_d;
    end
  end

  assign mode_o      = mode_q;
  assign bufen_o     = bufen_q;
  assign irq_stall_o = stl_q;
  assign irq_abort_o = abt_q;

  p_stall_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr_i && clr_wd_i[0] && !set_stall_i) |=> !irq_stall_o);
  p_abort_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr_i && clr_wd_i[1] && !set_abort_i) |=> !irq_abort_o);
  p_stall_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stall_o && !clr_wr_i) |=> irq_stall_o);
endmodule

// File: rtl/frwb_hold.sv
module frwb_hold #(
  parameter int AW = 16,
  parameter int LW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_en_i,
  input  logic          fill_i,
  input  logic [AW-1:0] fill_addr_i,
  input  logic [LW-1:0] fill_data_i,
  input  logic [AW-1:0] lk_addr_i,
  output logic          hit_o,
  output logic [LW-1:0] hit_data_o
);
  logic          vld_q, vld_d;
  logic [AW-1:0] tag_q;
  logic [LW-1:0] line_q;
  logic          load;

  assign load = buf_en_i && fill_i;

  always_comb begin
    vld_d = vld_q;
    if (!buf_en_i)  vld_d = 1'b0;
    else if (fill_i) vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      line_q <= '0;
    end else if (load) begin
      tag_q  <= fill_addr_i;
      line_q <= fill_data_i;
    end
  end

  assign hit_o      = buf_en_i && vld_q && (tag_q == lk_addr_i);
  assign hit_data_o = line_q;

  p_reenable_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_en_i) |-> !vld_q);
endmodule

// File: rtl/frwb_fsm.sv
module frwb_fsm #(
  parameter int AW = 16,
  parameter int LW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_i,
  input  logic          rd_req_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          hit_i,
  input  logic [LW-1:0] hit_data_i,
  input  logic          arr_busy_i,
  input  logic [LW-1:0] arr_rdata_i,
  output logic          rd_stall_o,
  output logic          rd_ack_o,
  output logic          rd_err_o,
  output logic [LW-1:0] rd_data_o,
  output logic          arr_rd_en_o,
  output logic [AW-1:0] arr_addr_o,
  output logic          arr_abort_o,
  output logic          fill_o,
  output logic [AW-1:0] fill_addr_o,
  output logic [LW-1:0] fill_data_o,
  output logic          set_stall_o,
  output logic          set_abort_o
);
  import frwb_pkg::*;

  rwb_st_e       st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          ack_q, ack_d;
  logic          err_q, err_d;
  logic [LW-1:0] data_q, data_d;
  logic          abt_q, abt_d;

  always_comb begin
    st_d        = st_q;
    addr_d      = addr_q;
    ack_d       = 1'b0;
    err_d       = 1'b0;
    data_d      = '0;
    abt_d       = 1'b0;
    arr_rd_en_o = 1'b0;
    arr_addr_o  = addr_q;
    fill_o      = 1'b0;
    set_stall_o = 1'b0;
    set_abort_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (rd_req_i) begin
          if (hit_i) begin
            ack_d  = 1'b1;
            data_d = hit_data_i;
          end else if (!arr_busy_i) begin
            arr_rd_en_o = 1'b1;
            arr_addr_o  = rd_addr_i;
            addr_d      = rd_addr_i;
            st_d        = ST_FETCH;
          end else if (!mode_i[2]) begin
            ack_d = 1'b1;
            err_d = 1'b1;
          end else begin
            addr_d      = rd_addr_i;
            st_d        = ST_STALL;
            abt_d       = !mode_i[1];
            set_stall_o = (mode_i == POL_STALL_IRQ);
            set_abort_o = (mode_i == POL_ABORT_IRQ);
          end
        end
      end
      ST_STALL: begin
        if (!arr_busy_i) begin
          arr_rd_en_o = 1'b1;
          st_d        = ST_FETCH;
        end
      end
      ST_FETCH: begin
        ack_d  = 1'b1;
        data_d = arr_rdata_i;
        fill_o = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      ack_q  <= 1'b0;
      err_q  <= 1'b0;
      data_q <= '0;
      abt_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      ack_q  <= ack_d;
      err_q  <= err_d;
      data_q <= data_d;
      abt_q  <= abt_d;
    end
  end

  assign rd_stall_o  = (st_q == ST_STALL);
  assign rd_ack_o    = ack_q;
  assign rd_err_o    = err_q;
  assign rd_data_o   = data_q;
  assign arr_abort_o = abt_q;
  assign fill_addr_o = addr_q;
  assign fill_data_o = arr_rdata_i;

  p_err_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err_o |-> $past(!mode_i[2]));
  p_no_read_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_en_o |-> !arr_busy_i);
  p_abort_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_abort_o |=> !arr_abort_o);
  p_abort_in_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_abort_o |-> rd_stall_o);
endmodule

// File: rtl/flash_rwb_ctrl.sv
module flash_rwb_ctrl #(
  parameter int AW = 16,
  parameter int LW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_mode_wd,
  input  logic          cfg_bufen_wd,
  input  logic          irq_clr_wr,
  input  logic [1:0]    irq_clr_wd,
  input  logic          bank_single,
  output logic [2:0]    cfg_mode_rd,
  output logic          cfg_bufen_rd,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_stall,
  output logic          rd_ack,
  output logic          rd_err,
  output logic [LW-1:0] rd_data,
  input  logic          arr_busy,
  output logic          arr_rd_en,
  output logic [AW-1:0] arr_addr,
  input  logic [LW-1:0] arr_rdata,
  output logic          arr_abort,
  output logic          irq_stall,
  output logic          irq_abort
);
  logic [2:0]    mode_q, mode_eff;
  logic          bufen_q;
  logic          hit;
  logic [LW-1:0] hit_data;
  logic          fill;
  logic [AW-1:0] fill_addr;
  logic [LW-1:0] fill_data;
  logic          set_stall, set_abort;

  assign mode_eff     = bank_single ? frwb_pkg::POL_STALL_ONLY : mode_q;
  assign cfg_mode_rd  = mode_q;
  assign cfg_bufen_rd = bufen_q;

  frwb_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_i    (cfg_wr),
    .mode_wd_i   (cfg_mode_wd),
    .bufen_wd_i  (cfg_bufen_wd),
    .clr_wr_i    (irq_clr_wr),
    .clr_wd_i    (irq_clr_wd),
    .set_stall_i (set_stall),
    .set_abort_i (set_abort),
    .mode_o      (mode_q),
    .bufen_o     (bufen_q),
    .irq_stall_o (irq_stall),
    .irq_abort_o (irq_abort)
  );

  frwb_hold #(.AW(AW), .LW(LW)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .buf_en_i    (bufen_q),
    .fill_i      (fill),
    .fill_addr_i (fill_addr),
    .fill_data_i (fill_data),
    .lk_addr_i   (rd_addr),
    .hit_o       (hit),
    .hit_data_o  (hit_data)
  );

  frwb_fsm #(.AW(AW), .LW(LW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_eff),
    .rd_req_i    (rd_req),
    .rd_addr_i   (rd_addr),
    .hit_i       (hit),
    .hit_data_i  (hit_data),
    .arr_busy_i  (arr_busy),
    .arr_rdata_i (arr_rdata),
    .rd_stall_o  (rd_stall),
    .rd_ack_o    (rd_ack),
    .rd_err_o    (rd_err),
    .rd_data_o   (rd_data),
    .arr_rd_en_o (arr_rd_en),
    .arr_addr_o  (arr_addr),
    .arr_abort_o (arr_abort),
    .fill_o      (fill),
    .fill_addr_o (fill_addr),
    .fill_data_o (fill_data),
    .set_stall_o (set_stall),
    .set_abort_o (set_abort)
  );

  p_single_no_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_single && $past(bank_single)) |-> !rd_err);
endmodule

// File: tb/flash_rwb_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_rwb_ctrl_tb_top;
  localparam int AW = 16;
  localparam int LW = 128;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr, cfg_bufen_wd, irq_clr_wr, bank_single;
  logic [2:0]    cfg_mode_wd;
  logic [1:0]    irq_clr_wd;
  logic [2:0]    cfg_mode_rd;
  logic          cfg_bufen_rd;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_stall, rd_ack, rd_err;
  logic [LW-1:0] rd_data;
  logic          arr_busy;
  logic          arr_rd_en;
  logic [AW-1:0] arr_addr;
  logic [LW-1:0] arr_rdata;
  logic          arr_abort, irq_stall, irq_abort;
  logic          bset, bclr;

  typedef struct {
    logic          err;
    logic [LW-1:0] data;
    int            cyc;
    string         req;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad = 0;
  int   cyc = 0;
  int   abort_cnt = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  flash_rwb_ctrl #(.AW(AW), .LW(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode_wd(cfg_mode_wd),
    .cfg_bufen_wd(cfg_bufen_wd), .irq_clr_wr(irq_clr_wr), .irq_clr_wd(irq_clr_wd),
    .bank_single(bank_single), .cfg_mode_rd(cfg_mode_rd), .cfg_bufen_rd(cfg_bufen_rd),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_stall(rd_stall), .rd_ack(rd_ack),
    .rd_err(rd_err), .rd_data(rd_data), .arr_busy(arr_busy), .arr_rd_en(arr_rd_en),
    .arr_addr(arr_addr), .arr_rdata(arr_rdata), .arr_abort(arr_abort),
    .irq_stall(irq_stall), .irq_abort(irq_abort)
  );

  function automatic logic [LW-1:0] line_of(logic [AW-1:0] a);
    return {16'h4444, a, 16'h3333, ~a, 16'h2222, a, 16'h1111, a ^ 16'h5a5a};
  endfunction

  // array model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (arr_rd_en) arr_rdata <= line_of(arr_addr);
    if (arr_abort) abort_cnt <= abort_cnt + 1;
    if (!rst_n)         arr_busy <= 1'b0;
    else if (arr_abort) arr_busy <= 1'b0;
    else if (bset)      arr_busy <= 1'b1;
    else if (bclr)      arr_busy <= 1'b0;
  end

  task automatic check(string req, logic [LW-1:0] act, logic [LW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rd_ack) begin
      if (q.size() == 0) begin
        total++; bad++;
        $display("FAIL unexpected ack: actual=1 expected=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        check({e.req, " err"}, LW'(rd_err), LW'(e.err));
        check({e.req, " data"}, rd_data, e.data);
        check({e.req, " cycle"}, LW'(cyc), LW'(e.cyc));
      end
    end
  end

  task automatic start_read(logic [AW-1:0] a, logic err, logic [LW-1:0] d, int lat, string req);
    exp_t e;
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a;
    e.err = err; e.data = d; e.cyc = cyc + lat; e.req = req;
    q.push_back(e);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wait_done();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(logic [2:0] m, logic be);
    @(negedge clk); cfg_wr = 1'b1; cfg_mode_wd = m; cfg_bufen_wd = be;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic go_busy();
    @(negedge clk); bset = 1'b1;
    @(negedge clk); bset = 1'b0;
  endtask

  task automatic release_after_two();
    @(negedge clk);
    @(negedge clk); bclr = 1'b1;
    @(negedge clk); bclr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ab0;
    rst_n = 1'b0; cfg_wr = 0; cfg_mode_wd = 0; cfg_bufen_wd = 0;
    irq_clr_wr = 0; irq_clr_wd = 0; bank_single = 0; rd_req = 0; rd_addr = 0;
    bset = 0; bclr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 mode", LW'(cfg_mode_rd), LW'(3'b111));
    check("R1 bufen", LW'(cfg_bufen_rd), LW'(1'b1));
    check("R1 irqs", LW'({irq_stall, irq_abort}), '0);
    check("R1 ack/stall", LW'({rd_ack, rd_stall}), '0);

    // R7 idle miss then R8 idle hit
    start_read(16'h0010, 0, line_of(16'h0010), 2, "R7 idle miss");
    wait_done();
    start_read(16'h0010, 0, line_of(16'h0010), 1, "R8 idle hit");
    wait_done();

    // R3 stall under 111
    go_busy();
    ab0 = abort_cnt;
    start_read(16'h0020, 0, line_of(16'h0020), 6, "R3 stall");
    check("R3 stall level", LW'(rd_stall), LW'(1'b1));
    release_after_two();
    wait_done();
    check("R3 no irq", LW'({irq_stall, irq_abort}), '0);
    check("R3 no abort", LW'(abort_cnt - ab0), '0);

    // R8 hit while busy, error policy; R2 error for miss
    set_cfg(3'b000, 1'b1);
    go_busy();
    start_read(16'h0020, 0, line_of(16'h0020), 1, "R8 busy hit");
    wait_done();
    start_read(16'h0030, 1, '0, 1, "R2 error");
    wait_done();
    set_cfg(3'b011, 1'b1);
    start_read(16'h0031, 1, '0, 1, "R2 error 011");
    wait_done();

    // R4 stall irq
    set_cfg(3'b110, 1'b1);
    ab0 = abort_cnt;
    start_read(16'h0040, 0, line_of(16'h0040), 6, "R4 stall irq");
    check("R4 irq_stall", LW'(irq_stall), LW'(1'b1));
    release_after_two();
    wait_done();
    check("R4 no abort", LW'({irq_abort, 1'(abort_cnt - ab0)}), '0);
    repeat (3) @(negedge clk);
    check("R10 level held", LW'(irq_stall), LW'(1'b1));
    @(negedge clk); irq_clr_wr = 1; irq_clr_wd = 2'b10;
    @(negedge clk); irq_clr_wr = 0;
    check("R10 other bit kept", LW'(irq_stall), LW'(1'b1));
    @(negedge clk); irq_clr_wr = 1; irq_clr_wd = 2'b01;
    @(negedge clk); irq_clr_wr = 0;
    check("R10 cleared", LW'(irq_stall), LW'(1'b0));

    // R5 abort without irq
    set_cfg(3'b101, 1'b1);
    go_busy();
    start_read(16'h0050, 0, line_of(16'h0050), 4, "R5 abort");
    check("R5 abort pulse", LW'(arr_abort), LW'(1'b1));
    @(negedge clk);
    check("R5 pulse width", LW'(arr_abort), LW'(1'b0));
    wait_done();
    check("R5 no irq_abort", LW'(irq_abort), LW'(1'b0));

    // R6 abort with irq
    set_cfg(3'b100, 1'b1);
    go_busy();
    start_read(16'h0060, 0, line_of(16'h0060), 4, "R6 abort irq");
    check("R6 abort pulse", LW'(arr_abort), LW'(1'b1));
    check("R6 irq_abort", LW'(irq_abort), LW'(1'b1));
    wait_done();
    check("R6 no stall irq", LW'(irq_stall), LW'(1'b0));
    @(negedge clk); irq_clr_wr = 1; irq_clr_wd = 2'b10;
    @(negedge clk); irq_clr_wr = 0;
    check("R10 abort cleared", LW'(irq_abort), LW'(1'b0));

    // R9 disable and invalidate (0x0060 is cached)
    set_cfg(3'b000, 1'b0);
    go_busy();
    start_read(16'h0060, 1, '0, 1, "R9 disabled");
    wait_done();
    set_cfg(3'b000, 1'b1);
    start_read(16'h0060, 1, '0, 1, "R9 invalidated");
    wait_done();

    // R11 single bank ignores policy 000
    bank_single = 1'b1;
    @(negedge clk);
    start_read(16'h0070, 0, line_of(16'h0070), 6, "R11 single bank");
    check("R11 stall", LW'(rd_stall), LW'(1'b1));
    release_after_two();
    wait_done();
    bank_single = 1'b0;

    repeat (3) @(negedge clk);
    check("queue empty", LW'(q.size()), '0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule